// File: doc/BRIEF.md
# Host Wake Access Handshake

This block holds the general-purpose control word through which a host wakes an internal processor domain before it touches resources inside that domain. The host sets an init-done bit to move the device into full operation. It then sets and holds an access request. A small sequencer models the domain's power-up delay and raises a clock-ready flag when the domain can be reached. When the request goes away and no other wake source remains, the sequencer shows a going-to-sleep flag for a fixed number of cycles. After that window it drops clock-ready and going-to-sleep together.

A software-reset input returns the host bits and the domain to the low-power state in one cycle. An oscillator-on request bit can be read and written. Two read-only fields follow external inputs: a 3-bit power-save type and the state of an RF-kill switch. Any change of the RF-kill switch sets a sticky event flag, which the host acknowledges through a separate input. The `host_ok` output is high only when the host may enter the domain.

Top module: `hwake_ctrl`

## Requirements
- R1: After reset, `ctrl_rd` has every bit at 0 except the mirrored inputs (bits 26:24 and 27), `host_ok` is 0 and `rfkill_irq` is 0.
- R2: Clock-ready (bit 0) never rises while init-done (bit 2) is 0. Clearing init-done while the domain is up starts the power-down sequence of R4, even if the access request (bit 3) is still held.
- R3: A write that sets init-done (bit 2) and the access request (bit 3) together makes clock-ready read 1 exactly PWRUP_CYC+1 cycles after the write edge.
- R4: Once no wake source remains, going-to-sleep (bit 4) reads 1 for exactly PWRDN_CYC cycles, starting one cycle after the removing edge. Clock-ready stays 1 during that window, and both flags clear on the same edge.
- R5: `host_ok` is 1 exactly when clock-ready is 1 and going-to-sleep is 0.
- R6: While init-done is set, the `aux_wake` input wakes the domain on its own (clock-ready after PWRUP_CYC+1 edges). It also keeps the domain awake when the access request is released.
- R7: A sleep window that has started always runs to completion. If a wake source returns during the window, the domain falls to off and then powers up again.
- R8: A `sw_reset` pulse clears access request, init-done, clock-ready and going-to-sleep at the next edge. It takes priority over a write in the same cycle and leaves the oscillator bit unchanged.
- R9: The oscillator-on request (bit 10) reads back the value last written.
- R10: Writes to the read-only bits 0, 4 and 24 to 27 have no effect, and all unassigned bits read 0.
- R11: Bits 26:24 show `ps_type_in` (000 none, 001 processor domain down, 010 radio down, 011 error) one cycle after it is applied.
- R12: Bit 27 shows `rfkill_in` one cycle late. Any change of `rfkill_in` sets `rfkill_irq` at the next edge. `rfkill_ack` clears it, and a change in the same cycle as an acknowledge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| sw_reset | input | 1 | Software reset pulse |
| aux_wake | input | 1 | Additional internal wake source |
| ps_type_in | input | 3 | Power-save type to mirror |
| rfkill_in | input | 1 | RF-kill switch level |
| rfkill_ack | input | 1 | Clears the RF-kill event flag |
| ctrl_rd | output | 32 | Control word readback |
| host_ok | output | 1 | Host may access internal resources |
| rfkill_irq | output | 1 | Sticky RF-kill change event |

## Verification
On every cycle, the assertions check the ordering rules of the handshake. Clock-ready may rise only after init-done. Going-to-sleep appears only while clock-ready is high and never lasts longer than the power-down window. Clock-ready falls only at the end of a full window or after a software reset. `host_ok` follows the two flags. The assertions also check that an RF-kill edge raises the event flag and that a software reset clears the host bits. Only the bench scenarios can show the exact power-up latency, an aux-held wake, a sleep that completes while a new request is pending, write priority against software reset, the oscillator and read-only bits, and the mirror latencies.

// File: rtl/hwake_pkg.sv
package hwake_pkg;

    localparam int REG_W       = 32;
    localparam int PS_W        = 3;
    localparam int BIT_CLK_RDY = 0;
    localparam int BIT_INIT    = 2;
    localparam int BIT_ACC_REQ = 3;
    localparam int BIT_GTS     = 4;
    localparam int BIT_OSC     = 10;
    localparam int BIT_PS_LO   = 24;
    localparam int BIT_RFK     = 27;

    typedef enum logic [1:0] {
        PWR_OFF,
        PWR_RISE,
        PWR_ON,
        PWR_FALL
    } pwr_state_e;

    typedef struct packed {
        logic osc_req;
        logic acc_req;
        logic init_done;
    } host_bits_t;

    typedef struct packed {
        logic clk_rdy;
        logic going_sleep;
    } pwr_stat_t;

    function automatic logic [REG_W-1:0] pack_ctrl(
        host_bits_t       hb,
        pwr_stat_t        ps,
        logic [PS_W-1:0]  ptype,
        logic             rfk
    );
        logic [REG_W-1:0] w;
        w = '0;
        w[BIT_CLK_RDY]          = ps.clk_rdy;
        w[BIT_INIT]             = hb.init_done;
        w[BIT_ACC_REQ]          = hb.acc_req;
        w[BIT_GTS]              = ps.going_sleep;
        w[BIT_OSC]              = hb.osc_req;
        w[BIT_PS_LO +: PS_W]    = ptype;
        w[BIT_RFK]              = rfk;
        return w;
    endfunction

endpackage

// File: rtl/hwake_hostreg.sv
module hwake_hostreg
    import hwake_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             sw_reset,
    output host_bits_t       hb
);
    // Software reset clears the wake-related bits and wins over a write.
    always_ff @(posedge clk) begin
        if (rst) begin
            hb <= '0;
        end else if (sw_reset) begin
            hb.acc_req   <= 1'b0;
            hb.init_done <= 1'b0;
        end else if (wr_en) begin
            hb.init_done <= wr_data[BIT_INIT];
            hb.acc_req   <= wr_data[BIT_ACC_REQ];
            hb.osc_req   <= wr_data[BIT_OSC];
        end
    end

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[REG_W-1:BIT_OSC+1], wr_data[BIT_OSC-1:BIT_ACC_REQ+1],
                              wr_data[BIT_INIT-1:0]};
endmodule

// File: rtl/hwake_pwr_seq.sv
module hwake_pwr_seq
    import hwake_pkg::*;
#(
    parameter int UP_CYC = 4,
    parameter int DN_CYC = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sw_reset,
    input  logic      wake_want,
    output pwr_stat_t st
);
    localparam int MAX_CYC = (UP_CYC > DN_CYC) ? UP_CYC : DN_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    pwr_state_e     state;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst || sw_reset) begin
            state <= PWR_OFF;
            cnt   <= '0;
        end else begin
            case (state)
                PWR_OFF: if (wake_want) begin
                    state <= PWR_RISE;
                    cnt   <= CW'(UP_CYC - 1);
                end
                PWR_RISE: begin
                    if (!wake_want)       state <= PWR_OFF;
                    else if (cnt == '0)   state <= PWR_ON;
                    else                  cnt   <= cnt - 1'b1;
                end
                PWR_ON: if (!wake_want) begin
                    state <= PWR_FALL;
                    cnt   <= CW'(DN_CYC - 1);
                end
                PWR_FALL: begin
                    // A started sleep always completes.
                    if (cnt == '0) state <= PWR_OFF;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= PWR_OFF;
            endcase
        end
    end

    assign st.clk_rdy     = (state == PWR_ON) || (state == PWR_FALL);
    assign st.going_sleep = (state == PWR_FALL);
endmodule

// File: rtl/hwake_rfk_mon.sv
module hwake_rfk_mon
    import hwake_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PS_W-1:0] ps_in,
    input  logic            rfk_in,
    input  logic            ack,
    output logic [PS_W-1:0] ps_q,
    output logic            rfk_q,
    output logic            irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q  <= '0;
            rfk_q <= rfk_in;
            irq   <= 1'b0;
        end else begin
            ps_q  <= ps_in;
            rfk_q <= rfk_in;
            if (rfk_in != rfk_q) irq <= 1'b1;
            else if (ack)        irq <= 1'b0;
        end
    end
endmodule

// File: rtl/hwake_ctrl.sv
module hwake_ctrl
    import hwake_pkg::*;
#(
    parameter int PWRUP_CYC = 4,
    parameter int PWRDN_CYC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             sw_reset,
    input  logic             aux_wake,
    input  logic [PS_W-1:0]  ps_type_in,
    input  logic             rfkill_in,
    input  logic             rfkill_ack,
    output logic [REG_W-1:0] ctrl_rd,
    output logic             host_ok,
    output logic             rfkill_irq
);
    host_bits_t      hb;
    pwr_stat_t       pst;
    logic [PS_W-1:0] ps_q;
    logic            rfk_q;
    logic            wake_want;

    hwake_hostreg u_hostreg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sw_reset (sw_reset),
        .hb       (hb)
    );

    // The domain may only wake after init-done.
    assign wake_want = hb.init_done & (hb.acc_req | aux_wake);

    hwake_pwr_seq #(.UP_CYC(PWRUP_CYC), .DN_CYC(PWRDN_CYC)) u_pwr (
        .clk       (clk),
        .rst       (rst),
        .sw_reset  (sw_reset),
        .wake_want (wake_want),
        .st        (pst)
    );

    hwake_rfk_mon u_rfk (
        .clk    (clk),
        .rst    (rst),
        .ps_in  (ps_type_in),
        .rfk_in (rfkill_in),
        .ack    (rfkill_ack),
        .ps_q   (ps_q),
        .rfk_q  (rfk_q),
        .irq    (rfkill_irq)
    );

    assign ctrl_rd = pack_ctrl(hb, pst, ps_q, rfk_q);
    assign host_ok = pst.clk_rdy & ~pst.going_sleep;
endmodule

// File: rtl/hwake_ctrl_chk.sv
module hwake_ctrl_chk #(
    parameter int DN_CYC = 3
) (
    input logic        clk,
    input logic        rst,
    input logic        sw_reset,
    input logic        rfkill_in,
    input logic [31:0] ctrl_rd,
    input logic        host_ok,
    input logic        rfkill_irq
);
    localparam int RW = $clog2(DN_CYC + 2);
    logic [RW-1:0] gts_run;

    always_ff @(posedge clk) begin
        if (rst)             gts_run <= '0;
        else if (ctrl_rd[4]) gts_run <= gts_run + 1'b1;
        else                 gts_run <= '0;
    end

    a_r2_ready_after_init: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_rd[0]) |-> $past(ctrl_rd[2]));

    a_r4_sleep_while_ready: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd[4] |-> ctrl_rd[0]);

    a_r4_sleep_bounded: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd[4] |-> (gts_run < RW'(DN_CYC)));

    a_r4_sleep_full: assert property (@(posedge clk) disable iff (rst)
        ($fell(ctrl_rd[4]) && !$past(sw_reset)) |-> (gts_run == RW'(DN_CYC)));

    a_r4_ready_drop: assert property (@(posedge clk) disable iff (rst)
        ($fell(ctrl_rd[0]) && !$past(sw_reset)) |-> $past(ctrl_rd[4]));

    a_r5_host_gate: assert property (@(posedge clk) disable iff (rst)
        host_ok |-> (ctrl_rd[0] && !ctrl_rd[4]));

    a_r8_sw_reset: assert property (@(posedge clk) disable iff (rst)
        sw_reset |=> (ctrl_rd[4:2] == 3'b000) && !ctrl_rd[0]);

    a_r12_rfk_event: assert property (@(posedge clk) disable iff (rst)
        (rfkill_in != ctrl_rd[27]) |=> rfkill_irq);
endmodule

bind hwake_ctrl hwake_ctrl_chk #(.DN_CYC(PWRDN_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sw_reset   (sw_reset),
    .rfkill_in  (rfkill_in),
    .ctrl_rd    (ctrl_rd),
    .host_ok    (host_ok),
    .rfkill_irq (rfkill_irq)
);

// File: tb/hwake_ctrl_test.sv
module hwake_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        sw_reset = 1'b0;
    logic        aux_wake = 1'b0;
    logic [2:0]  ps_type_in = '0;
    logic        rfkill_in = 1'b0;
    logic        rfkill_ack = 1'b0;
    logic [31:0] ctrl_rd;
    logic        host_ok;
    logic        rfkill_irq;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    hwake_ctrl uut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .sw_reset   (sw_reset),
        .aux_wake   (aux_wake),
        .ps_type_in (ps_type_in),
        .rfkill_in  (rfkill_in),
        .rfkill_ack (rfkill_ack),
        .ctrl_rd    (ctrl_rd),
        .host_ok    (host_ok),
        .rfkill_irq (rfkill_irq)
    );

    typedef struct {
        logic [31:0] rd;
        logic        ok;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // Expected word; host_ok follows ready and not-sleeping (R5).
    function automatic logic [31:0] w(bit rdy, bit init, bit req, bit gts, bit osc,
                                      logic [2:0] ps, bit rfk);
        logic [31:0] v;
        v = '0;
        v[0] = rdy; v[2] = init; v[3] = req; v[4] = gts; v[10] = osc;
        v[26:24] = ps; v[27] = rfk;
        return v;
    endfunction

    task automatic cyc(input bit we, input logic [31:0] wd, input bit sr,
                       input logic [31:0] exp_rd, input bit exp_irq, input string tag);
        exp_t e;
        @(negedge clk);
        wr_en = we; wr_data = wd; sw_reset = sr;
        @(posedge clk);
        #1;
        e.rd = exp_rd; e.ok = exp_rd[0] & ~exp_rd[4]; e.irq = exp_irq; e.tag = tag;
        sb.push_back(e);
        wr_en = 1'b0; wr_data = '0; sw_reset = 1'b0;
    endtask

    task automatic idle(input int n, input logic [31:0] exp_rd, input bit exp_irq,
                        input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, exp_rd, exp_irq, tag);
    endtask

    // Monitor: compare one expected item per cycle.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (ctrl_rd !== e.rd || host_ok !== e.ok || rfkill_irq !== e.irq) begin
                n_fail++;
                $display("FAIL %s: rd=%h ok=%b irq=%b expected rd=%h ok=%b irq=%b",
                         e.tag, ctrl_rd, host_ok, rfkill_irq, e.rd, e.ok, e.irq);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        idle(1, 32'h0, 0, "R1 reset state");

        // R2: request without init-done never wakes.
        cyc(1, 32'h8, 0, w(0,0,1,0,0,0,0), 0, "R2 req only");
        idle(7, w(0,0,1,0,0,0,0), 0, "R2 no ready without init");

        // R3: power-up latency.
        cyc(1, 32'hC, 0, w(0,1,1,0,0,0,0), 0, "R3 write");
        idle(4, w(0,1,1,0,0,0,0), 0, "R3 rising");
        idle(1, w(1,1,1,0,0,0,0), 0, "R3 ready");

        // R4/R5: release, sleep window.
        cyc(1, 32'h4, 0, w(1,1,0,0,0,0,0), 0, "R4 release");
        idle(3, w(1,1,0,1,0,0,0), 0, "R4 going to sleep");
        idle(1, w(0,1,0,0,0,0,0), 0, "R4 off");

        // R6: aux wake.
        aux_wake = 1'b1;
        idle(4, w(0,1,0,0,0,0,0), 0, "R6 aux rising");
        idle(1, w(1,1,0,0,0,0,0), 0, "R6 aux ready");
        cyc(1, 32'hC, 0, w(1,1,1,0,0,0,0), 0, "R6 req on");
        cyc(1, 32'h4, 0, w(1,1,0,0,0,0,0), 0, "R6 req off");
        idle(3, w(1,1,0,0,0,0,0), 0, "R6 aux holds");
        aux_wake = 1'b0;
        idle(3, w(1,1,0,1,0,0,0), 0, "R6 aux drop sleep");
        idle(1, w(0,1,0,0,0,0,0), 0, "R6 off");

        // R7: sleep completes despite new request.
        cyc(1, 32'hC, 0, w(0,1,1,0,0,0,0), 0, "R7 up");
        idle(4, w(0,1,1,0,0,0,0), 0, "R7 rising");
        idle(1, w(1,1,1,0,0,0,0), 0, "R7 ready");
        cyc(1, 32'h4, 0, w(1,1,0,0,0,0,0), 0, "R7 release");
        idle(1, w(1,1,0,1,0,0,0), 0, "R7 sleep start");
        cyc(1, 32'hC, 0, w(1,1,1,1,0,0,0), 0, "R7 re-request in window");
        idle(1, w(1,1,1,1,0,0,0), 0, "R7 window continues");
        idle(1, w(0,1,1,0,0,0,0), 0, "R7 reaches off");
        idle(4, w(0,1,1,0,0,0,0), 0, "R7 rising again");
        idle(1, w(1,1,1,0,0,0,0), 0, "R7 ready again");

        // R2: clearing init-done with request held powers down.
        cyc(1, 32'h8, 0, w(1,0,1,0,0,0,0), 0, "R2 init clear");
        idle(3, w(1,0,1,1,0,0,0), 0, "R2 sleeping");
        idle(1, w(0,0,1,0,0,0,0), 0, "R2 off");

        // R9/R8: oscillator bit, software reset priority.
        cyc(1, 32'h40C, 0, w(0,1,1,0,1,0,0), 0, "R9 osc write");
        idle(4, w(0,1,1,0,1,0,0), 0, "R9 rising");
        idle(1, w(1,1,1,0,1,0,0), 0, "R9 ready");
        cyc(1, 32'hC, 1, w(0,0,0,0,1,0,0), 0, "R8 sw reset beats write");
        idle(2, w(0,0,0,0,1,0,0), 0, "R8 stays off");

        // R10: read-only bits ignored.
        cyc(1, 32'h0F00_0011, 0, 32'h0, 0, "R10 ro bits");
        cyc(1, 32'hF0FF_FBF3, 0, 32'h0, 0, "R10 unused bits");

        // R11: power-save type mirror.
        ps_type_in = 3'b010;
        idle(1, w(0,0,0,0,0,3'b010,0), 0, "R11 radio down");
        ps_type_in = 3'b011;
        idle(1, w(0,0,0,0,0,3'b011,0), 0, "R11 error");
        ps_type_in = 3'b000;
        idle(1, 32'h0, 0, "R11 none");

        // R12: RF-kill mirror and event.
        rfkill_in = 1'b1;
        idle(1, w(0,0,0,0,0,0,1), 1, "R12 switch on");
        idle(1, w(0,0,0,0,0,0,1), 1, "R12 sticky");
        rfkill_ack = 1'b1;
        idle(1, w(0,0,0,0,0,0,1), 0, "R12 ack");
        rfkill_in = 1'b0;
        idle(1, 32'h0, 1, "R12 change beats ack");
        idle(1, 32'h0, 0, "R12 ack again");
        rfkill_ack = 1'b0;
        idle(1, 32'h0, 0, "R12 idle");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule